// File: doc/BRIEF.md
# Masked Internal Register Access Unit

This block holds the 64-bit internal control registers of a processor core. Each register is selected by a 6-bit index and accessed with a read strobe or a write strobe. Every writable register keeps only the bits its write mask allows. A few status registers clear on any write. Some indices can only be read and some can only be written. An access of the wrong kind, or to an unused index, is reported on a fault output and has no effect.

Three indices do more than store a value. A cycle-counter read combines the stored upper half with a live count from the core. A page-table-entry read packs the fields presented by the translation buffer into one word. Writes to the translation-buffer invalidate indices produce one-cycle strobes for the buffers, which live outside this block. A suppress input blocks all writes, for example while the core is on a mispredicted path.

Top module: `ipr_bank`

## Requirements
- R1: After reset every stored register reads zero, except index 42 (machine control), which reads 0x6, and index 24 (privileged base), which reads the BASE_RESET parameter.
- R2: Indices 0–24, 42, 43 and 44 store the full 64-bit write value. A read returns data combinationally in the cycle the read strobe is high. A write becomes visible after the next rising clock edge.
- R3: Writes are masked per index. Index 25 clears bit 1. Indices 26 and 27 keep 0xf. Index 28 keeps 0x1f. Indices 29 and 30 keep 0x18. Index 31 keeps 0x7fff0. Index 32 keeps 0xffffff0300. Indices 33 and 34 keep bits 63:30. Index 35 keeps 0x1ffb. Indices 36 and 37 keep 0x3f. Index 38 keeps 0x7f0. Index 39 keeps bits 63:57.
- R4: Indices 40 (exception summary) and 41 (exception mask) become zero on any write, whatever the data. When `exc_post` is high, they load `exc_sum_in` and `exc_mask_in`, and this load wins over a write in the same cycle.
- R5: Indices 45–49 are read-only. A write to them raises `wr_fault` and changes nothing. Reading 46 returns `intr_id_in` zero-extended, 47 returns `mm_stat_in`, and 48 and 49 return zero.
- R6: Indices 50–60 are write-only and 61–63 are undefined. A read of any index from 50 to 63 raises `rd_fault` and returns data 0. A write to 61–63 raises `wr_fault`. A write to 50–60 raises no fault.
- R7: Reading index 44 returns bits 63:32 of the stored register in the upper half and `live_cycles` in the lower half.
- R8: Reading index 45 returns a packed word, with the fields ORed together where they overlap. `pte_ppn` sits at bits 58:32, `pte_rd_en` at 11:8, `pte_wr_en` at 15:12, `pte_fault_rd` at bit 1, `pte_fault_wr` at bit 2, `pte_asm` at bit 4 and `pte_asn` at 63:57. All other bits are zero.
- R9: A write to an invalidate index raises the matching strobe for exactly the one cycle after the write edge. The mapping is: 55 to `dtlb_inv_all`, 56 to `dtlb_inv_proc`, 57 to `itlb_inv_all`, 58 to `itlb_inv_proc`, 59 to `dtlb_inv_one` and 60 to `itlb_inv_one`. A write to 59 or 60 also loads `inv_va` with the written value.
- R10: While `wr_suppress` is high, a write changes no register, raises no strobe and reports no fault.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| idx | input | 6 | Register index |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 64 | Write value |
| wr_suppress | input | 1 | Blocks writes |
| live_cycles | input | 32 | Running cycle count |
| intr_id_in | input | 5 | Current interrupt identifier |
| mm_stat_in | input | 64 | Memory-management status |
| exc_post | input | 1 | Loads exception summary and mask |
| exc_sum_in | input | 64 | Exception summary to load |
| exc_mask_in | input | 64 | Exception mask to load |
| pte_ppn | input | 27 | Page number of the selected entry |
| pte_rd_en | input | 4 | Read enables per mode |
| pte_wr_en | input | 4 | Write enables per mode |
| pte_fault_rd | input | 1 | Fault-on-read flag |
| pte_fault_wr | input | 1 | Fault-on-write flag |
| pte_asm | input | 1 | Address-space-match flag |
| pte_asn | input | 7 | Address-space number |
| rd_data | output | 64 | Read result |
| rd_fault | output | 1 | Read of a write-only or undefined index |
| wr_fault | output | 1 | Write to a read-only or undefined index |
| dtlb_inv_all | output | 1 | Data buffer invalidate-all strobe |
| dtlb_inv_proc | output | 1 | Data buffer invalidate-process strobe |
| dtlb_inv_one | output | 1 | Data buffer single-address strobe |
| itlb_inv_all | output | 1 | Instruction buffer invalidate-all strobe |
| itlb_inv_proc | output | 1 | Instruction buffer invalidate-process strobe |
| itlb_inv_one | output | 1 | Instruction buffer single-address strobe |
| inv_va | output | 64 | Address for single-address invalidates |

## Verification
The bench sweeps all 64 indices with several data patterns and checks each read-back against a mask table it computes itself. A design with a wrong or shifted mask would keep stray bits, for example bit 1 of the exception address or the low nibble of the software request. The read-only, write-only and undefined boundaries at 45, 50 and 61 are probed on both sides. An off-by-one decode would either fault a legal access or let a forbidden write corrupt a register. The bench also covers a clear-on-write colliding with a hardware post, the cycle-counter half merge, and the overlapping bits of the packed entry view. Suppressed writes are replayed over every index, to catch a design that stores the value, fires a strobe or reports a fault while suppressed.

// File: rtl/ipr_bank.sv
module ipr_bank #(
  parameter logic [63:0] BASE_RESET = 64'h0000_0000_0000_4000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  idx,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [63:0] wr_data,
  input  logic        wr_suppress,
  input  logic [31:0] live_cycles,
  input  logic [4:0]  intr_id_in,
  input  logic [63:0] mm_stat_in,
  input  logic        exc_post,
  input  logic [63:0] exc_sum_in,
  input  logic [63:0] exc_mask_in,
  input  logic [26:0] pte_ppn,
  input  logic [3:0]  pte_rd_en,
  input  logic [3:0]  pte_wr_en,
  input  logic        pte_fault_rd,
  input  logic        pte_fault_wr,
  input  logic        pte_asm,
  input  logic [6:0]  pte_asn,
  output logic [63:0] rd_data,
  output logic        rd_fault,
  output logic        wr_fault,
  output logic        dtlb_inv_all,
  output logic        dtlb_inv_proc,
  output logic        dtlb_inv_one,
  output logic        itlb_inv_all,
  output logic        itlb_inv_proc,
  output logic        itlb_inv_one,
  output logic [63:0] inv_va
);

  localparam int NSTORE = 45;
  localparam logic [5:0] IX_BASE = 6'd24, IX_SUM = 6'd40, IX_MSK = 6'd41;
  localparam logic [5:0] IX_MCTL = 6'd42, IX_CC = 6'd44, IX_PTE = 6'd45;
  localparam logic [5:0] IX_IID = 6'd46, IX_MMS = 6'd47, IX_RO_HI = 6'd49;
  localparam logic [5:0] IX_WO_LO = 6'd50, IX_UNDEF = 6'd61;

  function automatic logic [63:0] wmask(input logic [5:0] i);
    case (i)
      6'd25:        wmask = ~64'h2;
      6'd26, 6'd27: wmask = 64'hf;
      6'd28:        wmask = 64'h1f;
      6'd29, 6'd30: wmask = 64'h18;
      6'd31:        wmask = 64'h7fff0;
      6'd32:        wmask = 64'hff_ffff_0300;
      6'd33, 6'd34: wmask = 64'hffff_ffff_c000_0000;
      6'd35:        wmask = 64'h1ffb;
      6'd36, 6'd37: wmask = 64'h3f;
      6'd38:        wmask = 64'h7f0;
      6'd39:        wmask = 64'hfe00_0000_0000_0000;
      6'd40, 6'd41: wmask = 64'h0;
      default:      wmask = '1;
    endcase
  endfunction

  logic [63:0] bank [NSTORE];
  logic        wr_act, is_ro, is_undef, is_store;
  logic [63:0] pte_word;

  assign wr_act   = wr_en && !wr_suppress;
  assign is_ro    = (idx >= IX_PTE) && (idx <= IX_RO_HI);
  assign is_undef = (idx >= IX_UNDEF);
  assign is_store = (idx < 6'(NSTORE));
  assign wr_fault = wr_act && (is_ro || is_undef);
  assign rd_fault = rd_en && (idx >= IX_WO_LO);

  assign pte_word = ({37'd0, pte_ppn} << 32) | ({57'd0, pte_asn} << 57) |
                    {48'd0, pte_wr_en, pte_rd_en, 3'd0, pte_asm, 1'b0,
                     pte_fault_wr, pte_fault_rd, 1'b0};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int k = 0; k < NSTORE; k++) bank[k] <= '0;
      bank[IX_BASE] <= BASE_RESET;
      bank[IX_MCTL] <= 64'h6;
    end else begin
      if (wr_act && is_store) bank[idx] <= wr_data & wmask(idx);
      if (exc_post) begin
        bank[IX_SUM] <= exc_sum_in;
        bank[IX_MSK] <= exc_mask_in;
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_en && !rd_fault) begin
      case (idx)
        IX_CC:   rd_data = {bank[IX_CC][63:32], live_cycles};
        IX_PTE:  rd_data = pte_word;
        IX_IID:  rd_data = {59'd0, intr_id_in};
        IX_MMS:  rd_data = mm_stat_in;
        default: if (idx < IX_CC) rd_data = bank[idx];
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      {dtlb_inv_all, dtlb_inv_proc, itlb_inv_all, itlb_inv_proc} <= '0;
      {dtlb_inv_one, itlb_inv_one} <= '0;
      inv_va <= '0;
    end else begin
      dtlb_inv_all  <= wr_act && (idx == 6'd55);
      dtlb_inv_proc <= wr_act && (idx == 6'd56);
      itlb_inv_all  <= wr_act && (idx == 6'd57);
      itlb_inv_proc <= wr_act && (idx == 6'd58);
      dtlb_inv_one  <= wr_act && (idx == 6'd59);
      itlb_inv_one  <= wr_act && (idx == 6'd60);
      if (wr_act && (idx == 6'd59 || idx == 6'd60)) inv_va <= wr_data;
    end
  end

  AST_FAULTED_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    rd_fault |-> rd_data == 64'd0); // R6
  AST_SUPPRESS_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_suppress) |-> !wr_fault); // R10
  AST_SUPPRESS_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_suppress) |=> !(dtlb_inv_all || dtlb_inv_proc || dtlb_inv_one ||
                                 itlb_inv_all || itlb_inv_proc || itlb_inv_one)); // R10
  AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dtlb_inv_all, dtlb_inv_proc, dtlb_inv_one,
              itlb_inv_all, itlb_inv_proc, itlb_inv_one})); // R9
  AST_SUM_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_suppress && idx == IX_SUM && !exc_post) |=> bank[IX_SUM] == 64'd0); // R4
  AST_RO_WRITE_FAULTS: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_suppress && idx >= IX_PTE && idx <= IX_RO_HI) |-> wr_fault); // R5

endmodule

// File: tb/test_ipr_bank.sv
module test_ipr_bank;
  localparam time PERIOD = 10ns;
  localparam logic [63:0] BASE = 64'h0000_0000_0000_4000;

  logic clk = 0, rst_n = 0;
  logic [5:0] idx = '0;
  logic rd_en = 0, wr_en = 0, wr_suppress = 0, exc_post = 0;
  logic [63:0] wr_data = '0, mm_stat_in = '0, exc_sum_in = '0, exc_mask_in = '0;
  logic [31:0] live_cycles = '0;
  logic [4:0] intr_id_in = '0;
  logic [26:0] pte_ppn = '0;
  logic [3:0] pte_rd_en = '0, pte_wr_en = '0;
  logic pte_fault_rd = 0, pte_fault_wr = 0, pte_asm = 0;
  logic [6:0] pte_asn = '0;
  logic [63:0] rd_data, inv_va;
  logic rd_fault, wr_fault;
  logic dtlb_inv_all, dtlb_inv_proc, dtlb_inv_one, itlb_inv_all, itlb_inv_proc, itlb_inv_one;

  int n_chk = 0, n_bad = 0;
  bit done = 0;
  logic [63:0] model [45];
  logic [63:0] lcg = 64'h1234_5678_9abc_def1;

  ipr_bank #(.BASE_RESET(BASE)) i_ipr_bank (.*);

  always #(PERIOD/2) clk = ~clk;

  function automatic logic [63:0] mask_of(input int i);
    case (i)
      25: return ~64'h2;
      26, 27: return 64'hf;
      28: return 64'h1f;
      29, 30: return 64'h18;
      31: return 64'h7fff0;
      32: return 64'hff_ffff_0300;
      33, 34: return 64'hffff_ffff_c000_0000;
      35: return 64'h1ffb;
      36, 37: return 64'h3f;
      38: return 64'h7f0;
      39: return 64'hfe00_0000_0000_0000;
      40, 41: return 64'h0;
      default: return '1;
    endcase
  endfunction

  function automatic logic [63:0] exp_read(input int i);
    logic [63:0] p;
    if (i == 44) return {model[44][63:32], live_cycles};
    if (i < 45) return model[i];
    if (i == 45) begin
      p = (64'(pte_ppn) << 32) | (64'(pte_asn) << 57) | (64'(pte_rd_en) << 8) |
          (64'(pte_wr_en) << 12) | (64'(pte_fault_rd) << 1) | (64'(pte_fault_wr) << 2) |
          (64'(pte_asm) << 4);
      return p;
    end
    if (i == 46) return 64'(intr_id_in);
    if (i == 47) return mm_stat_in;
    return '0;
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [63:0] next_rand();
    lcg = lcg * 64'd6364136223846793005 + 64'd1442695040888963407;
    return lcg;
  endfunction

  task automatic do_read(input int i, input string req);
    @(negedge clk); idx = 6'(i); rd_en = 1; #1;
    chk({req, " data"}, rd_data, exp_read(i));
    chk("R6 rd_fault", 64'(rd_fault), 64'(i >= 50));
    rd_en = 0;
  endtask

  task automatic do_write(input int i, input logic [63:0] d, input bit sup);
    logic [5:0] s;
    @(negedge clk); idx = 6'(i); wr_data = d; wr_en = 1; wr_suppress = sup; #1;
    chk(sup ? "R10 no fault" : "R5/R6 wr_fault", 64'(wr_fault),
        64'(!sup && ((i >= 45 && i <= 49) || i >= 61)));
    @(negedge clk); wr_en = 0; wr_suppress = 0;
    s = '0;
    if (!sup && i >= 55 && i <= 60) s[i-55] = 1'b1;
    chk(sup ? "R10 strobes" : "R9 strobes",
        64'({itlb_inv_one, dtlb_inv_one, itlb_inv_proc, itlb_inv_all, dtlb_inv_proc, dtlb_inv_all}),
        64'(s));
    if (!sup && (i == 59 || i == 60)) chk("R9 inv_va", inv_va, d);
    if (!sup && i < 45) model[i] = d & mask_of(i);
  endtask

  task automatic sweep_read(input string req);
    for (int i = 0; i < 64; i++) do_read(i, req);
  endtask

  initial begin
    #(PERIOD * 190000);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [63:0] pats [3];
    for (int i = 0; i < 45; i++) model[i] = '0;
    model[24] = BASE; model[42] = 64'h6;
    intr_id_in = 5'h13; mm_stat_in = 64'hdead_beef_0000_1111;
    pte_ppn = 27'h5a5_a5a5; pte_asn = 7'h7f; pte_rd_en = 4'ha; pte_wr_en = 4'h5;
    pte_fault_rd = 1; pte_asm = 1; live_cycles = 32'h0bad_cafe;
    repeat (3) @(negedge clk);
    rst_n = 1;
    sweep_read("R1 reset");

    pats[0] = '1; pats[1] = 64'ha5a5_5a5a_f0f0_0f0f; pats[2] = next_rand();
    for (int p = 0; p < 3; p++) begin
      live_cycles = next_rand()[31:0];
      for (int i = 0; i < 64; i++) do_write(i, pats[p] ^ 64'(i), 0);
      sweep_read("R2/R3 readback");
    end

    for (int i = 0; i < 45; i++) do_write(i, next_rand(), 0);
    sweep_read("R3 random");

    // R4: hardware post, collision, then clear-on-write
    @(negedge clk); exc_post = 1; exc_sum_in = 64'h1111_2222_3333_4444; exc_mask_in = 64'h8000_0000_0000_0001;
    @(negedge clk); exc_post = 0;
    model[40] = exc_sum_in; model[41] = exc_mask_in;
    do_read(40, "R4 post sum"); do_read(41, "R4 post mask");
    @(negedge clk); idx = 6'd40; wr_data = '1; wr_en = 1; exc_post = 1; exc_sum_in = 64'h77; exc_mask_in = 64'h99;
    @(negedge clk); wr_en = 0; exc_post = 0;
    model[40] = 64'h77; model[41] = 64'h99;
    do_read(40, "R4 post wins"); do_read(41, "R4 post wins mask");
    do_write(40, '1, 0); do_read(40, "R4 clear sum"); do_read(41, "R4 mask kept");
    do_write(41, 64'h5, 0); do_read(41, "R4 clear mask");

    // R10: suppressed writes everywhere
    for (int i = 0; i < 64; i++) do_write(i, ~(64'(i) * 64'h0101_0101_0101_0101), 1);
    sweep_read("R10 unchanged");

    // R7 cycle-counter merge
    do_write(44, 64'hfeed_face_1234_5678, 0);
    for (int k = 0; k < 4; k++) begin
      live_cycles = next_rand()[31:0];
      do_read(44, "R7 cc merge");
    end

    // R8 packed entry view
    for (int k = 0; k < 8; k++) begin
      {pte_ppn, pte_asn, pte_rd_en, pte_wr_en, pte_fault_rd, pte_fault_wr, pte_asm} = 45'(next_rand());
      do_read(45, "R8 pte pack");
    end
    pte_ppn = '0; pte_asn = '0; pte_rd_en = '0; pte_wr_en = '0;
    {pte_fault_rd, pte_fault_wr, pte_asm} = 3'b010;
    do_read(45, "R8 single flag");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule